// File: doc/BRIEF.md
# Capture configuration packet decoder

This block sits behind the host-to-device endpoint FIFO of a 32-channel logic capture engine. It takes a byte stream on a valid/ready interface and finds fixed-layout command packets in it. Each packet sets the sample-rate code, trigger enables, two threshold PWM words, the sample depth, the pretrigger depth and two trigger descriptor records. Its closing two-byte command code selects one of three actions: start capture, report status or read out captured data.

Bytes are taken in only after a two-byte header is seen. The body goes into a shadow store. The live configuration registers change only when a start command arrives and its depth pair passes the depth checks. For a valid start, the block pulses `start_pulse` and clears `param_err`. For an invalid start, it sets `param_err` and gives no pulse. Status and readout commands pulse their own output and leave the configuration and `param_err` unchanged.

Back-pressure: a byte moves when `in_valid` and `in_ready` are both high at a rising clock edge. `in_data` is read only in that cycle. `in_ready` is high at all times except for the single cycle after the final byte of a packet has been accepted, while the command is resolved. The sender may remove `in_valid` between any two bytes.

Top module: `cfg_packet_decoder`

## Requirements
- R1: A packet starts with byte 0x7F followed directly by byte 0x01. Other bytes are discarded while no header has been seen. After a 0x7F, a byte that is neither 0x01 nor 0x7F restarts the search, so the sequence 0x7F 0x7F 0x01 still synchronises.
- R2: The packet is 84 bytes long and its multi-byte fields are little-endian. The byte offsets are:
  - 2: rate code
  - 3: trigger flags
  - 4–5: PWM A
  - 6–7: PWM B
  - 8–9: unused
  - 10–13: sample depth
  - 14–17: pretrigger depth
  - 18–49: trigger 1 record
  - 50–81: trigger 2 record
  - 82–83: command

  Each record is eight 32-bit words, and word k appears at bits [32k+31:32k] of its output.
- R3: Command bytes 0x1A then 0x2B with a valid depth pair load every configuration output. `start_pulse` is then high for exactly one cycle, in the second cycle after the final byte is accepted. The configuration outputs change at no other time.
- R4: Command bytes 0x3A then 0x4B give a one-cycle `status_pulse` with the same timing as R3. The configuration outputs and `param_err` do not change.
- R5: Command bytes 0x5A then 0x6B give a one-cycle `readout_pulse` with the same timing as R3. The configuration outputs do not change.
- R6: A depth pair is valid only when all of these hold:
  - the sample depth is at least 2048;
  - the sample depth is at most 67108864;
  - the sample depth is a multiple of 512;
  - the pretrigger depth is strictly less than the sample depth.

  A start with an invalid pair sets `param_err`, gives no pulse and leaves the configuration unchanged. A valid start clears `param_err`.
- R7: In the trigger flags byte, bit 0 drives `trig1_en` and bit 1 drives `trig2_en`. Bit 2 drives `trig_and`, where 1 means AND-combine and 0 means OR-combine.
- R8: Each 16-bit PWM word is output as 12 bits. A value above 4095 saturates to 4095.
- R9: A packet with any other command code changes no output and gives no pulse.
- R10: `in_ready` is low only in the one cycle after a packet's final byte is accepted. At most one of the three pulses is high in any cycle.
- R11: After reset, all configuration outputs, pulses and `param_err` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| rate_code | output | 8 | Applied sample-rate code |
| trig1_en | output | 1 | Trigger 1 enabled |
| trig2_en | output | 1 | Trigger 2 enabled |
| trig_and | output | 1 | 1: triggers AND-combined, 0: OR-combined |
| pwm_a | output | PWM_BITS | Threshold A PWM value, saturated |
| pwm_b | output | PWM_BITS | Threshold B PWM value, saturated |
| sample_depth | output | 32 | Applied sample depth |
| pre_depth | output | 32 | Applied pretrigger depth |
| trig1_rec | output | TRIG_WORDS*32 | Trigger 1 descriptor words |
| trig2_rec | output | TRIG_WORDS*32 | Trigger 2 descriptor words |
| start_pulse | output | 1 | One-cycle start-capture request |
| status_pulse | output | 1 | One-cycle status request |
| readout_pulse | output | 1 | One-cycle data readout request |
| param_err | output | 1 | Last start command carried an invalid depth pair |

## Verification
On every cycle, the assertions check that:
- at most one pulse is high at a time, and each pulse lasts one cycle;
- the configuration changes only together with `start_pulse`, and only to a depth pair that passes R6;
- `param_err` rises only without a start and falls only with one;
- `in_ready` never stays low for two cycles in a row.

Some behaviour only the bench scenarios can show: field placement and byte order, PWM saturation, and header resynchronisation after junk bytes. The same holds for rejection at each depth boundary, the exact cycle of each pulse, and the absence of any effect from unknown commands.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam logic [7:0] HDR_B0      = 8'h7F;
  localparam logic [7:0] HDR_B1      = 8'h01;
  localparam logic [7:0] CMD_START_0 = 8'h1A;
  localparam logic [7:0] CMD_START_1 = 8'h2B;
  localparam logic [7:0] CMD_STAT_0  = 8'h3A;
  localparam logic [7:0] CMD_STAT_1  = 8'h4B;
  localparam logic [7:0] CMD_READ_0  = 8'h5A;
  localparam logic [7:0] CMD_READ_1  = 8'h6B;

  localparam int OFF_RATE  = 0;
  localparam int OFF_FLAGS = 1;
  localparam int OFF_PWMA  = 2;
  localparam int OFF_PWMB  = 4;
  localparam int OFF_SPARE = 6;
  localparam int OFF_DEPTH = 8;
  localparam int OFF_PRE   = 12;
  localparam int OFF_TRIG1 = 16;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_HDR,
    ST_BODY,
    ST_COMMIT
  } frame_state_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_START,
    CMD_STATUS,
    CMD_READ
  } cmd_kind_e;
endpackage

// File: rtl/cfgdec_framer.sv
module cfgdec_framer
  import cfgdec_pkg::*;
#(
  parameter int BODY_LEN = 82,
  localparam int IDX_W = $clog2(BODY_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             commit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BODY_LEN - 1);

  frame_state_e     state_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept;

  always_comb begin
    in_ready = (state_q != ST_COMMIT);
    commit   = (state_q == ST_COMMIT);
    accept   = in_valid && in_ready;
    wr_en    = accept && (state_q == ST_BODY);
    wr_idx   = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          if (accept && in_data == HDR_B0) state_q <= ST_HDR;
        end
        ST_HDR: begin
          if (accept) begin
            if (in_data == HDR_B1) begin
              state_q <= ST_BODY;
              idx_q   <= '0;
            end else if (in_data != HDR_B0) begin
              state_q <= ST_HUNT;
            end
          end
        end
        ST_BODY: begin
          if (accept) begin
            if (idx_q == LAST_IDX) state_q <= ST_COMMIT;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/cfgdec_shadow.sv
module cfgdec_shadow
  import cfgdec_pkg::*;
#(
  parameter int BODY_LEN = 82,
  localparam int IDX_W = $clog2(BODY_LEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [BODY_LEN*8-1:0] body
);
  for (genvar i = 0; i < BODY_LEN; i++) begin : g_byte
    if (i == OFF_SPARE || i == OFF_SPARE + 1) begin : g_skip
      assign body[8*i +: 8] = '0;
    end else begin : g_keep
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))      q <= wr_data;
      end
      assign body[8*i +: 8] = q;
    end
  end
endmodule

// File: rtl/cfgdec_check.sv
module cfgdec_check
  import cfgdec_pkg::*;
#(
  parameter int TRIG_WORDS = 8,
  parameter int PWM_BITS   = 12,
  parameter int MIN_DEPTH  = 2048,
  parameter int MAX_DEPTH  = 67108864,
  parameter int ALIGN_BITS = 9,
  localparam int REC_W     = TRIG_WORDS * 32,
  localparam int REC_BYTES = TRIG_WORDS * 4,
  localparam int BODY_LEN  = OFF_TRIG1 + 2 * REC_BYTES + 2
) (
  input  logic [BODY_LEN*8-1:0] body,
  output logic [7:0]            rate_code,
  output logic                  trig1_en,
  output logic                  trig2_en,
  output logic                  trig_and,
  output logic [PWM_BITS-1:0]   pwm_a,
  output logic [PWM_BITS-1:0]   pwm_b,
  output logic [31:0]           sample_depth,
  output logic [31:0]           pre_depth,
  output logic [REC_W-1:0]      trig1_rec,
  output logic [REC_W-1:0]      trig2_rec,
  output cmd_kind_e             kind,
  output logic                  depth_ok
);
  localparam int OFF_TRIG2 = OFF_TRIG1 + REC_BYTES;
  localparam int OFF_CMD   = OFF_TRIG2 + REC_BYTES;
  localparam logic [15:0] PWM_MAX = 16'((1 << PWM_BITS) - 1);

  logic [7:0]  flags;
  logic [15:0] raw_a;
  logic [15:0] raw_b;
  logic [7:0]  cmd0;
  logic [7:0]  cmd1;
  logic        unused_bits;

  always_comb begin
    rate_code    = body[8*OFF_RATE +: 8];
    flags        = body[8*OFF_FLAGS +: 8];
    raw_a        = body[8*OFF_PWMA +: 16];
    raw_b        = body[8*OFF_PWMB +: 16];
    sample_depth = body[8*OFF_DEPTH +: 32];
    pre_depth    = body[8*OFF_PRE +: 32];
    trig1_rec    = body[8*OFF_TRIG1 +: REC_W];
    trig2_rec    = body[8*OFF_TRIG2 +: REC_W];
    cmd0         = body[8*OFF_CMD +: 8];
    cmd1         = body[8*(OFF_CMD+1) +: 8];

    trig1_en = flags[0];
    trig2_en = flags[1];
    trig_and = flags[2];

    pwm_a = (raw_a > PWM_MAX) ? PWM_MAX[PWM_BITS-1:0] : raw_a[PWM_BITS-1:0];
    pwm_b = (raw_b > PWM_MAX) ? PWM_MAX[PWM_BITS-1:0] : raw_b[PWM_BITS-1:0];

    depth_ok = (sample_depth >= 32'(MIN_DEPTH)) &&
               (sample_depth <= 32'(MAX_DEPTH)) &&
               (sample_depth[ALIGN_BITS-1:0] == '0) &&
               (pre_depth < sample_depth);

    if      (cmd0 == CMD_START_0 && cmd1 == CMD_START_1) kind = CMD_START;
    else if (cmd0 == CMD_STAT_0  && cmd1 == CMD_STAT_1)  kind = CMD_STATUS;
    else if (cmd0 == CMD_READ_0  && cmd1 == CMD_READ_1)  kind = CMD_READ;
    else                                                 kind = CMD_NONE;
  end

  assign unused_bits = ^{flags[7:3], body[8*OFF_SPARE +: 16]};
endmodule

// File: rtl/cfg_packet_decoder.sv
module cfg_packet_decoder
  import cfgdec_pkg::*;
#(
  parameter int TRIG_WORDS = 8,
  parameter int PWM_BITS   = 12,
  parameter int MIN_DEPTH  = 2048,
  parameter int MAX_DEPTH  = 67108864,
  parameter int ALIGN_BITS = 9,
  localparam int REC_W     = TRIG_WORDS * 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  output logic [7:0]          rate_code,
  output logic                trig1_en,
  output logic                trig2_en,
  output logic                trig_and,
  output logic [PWM_BITS-1:0] pwm_a,
  output logic [PWM_BITS-1:0] pwm_b,
  output logic [31:0]         sample_depth,
  output logic [31:0]         pre_depth,
  output logic [REC_W-1:0]    trig1_rec,
  output logic [REC_W-1:0]    trig2_rec,
  output logic                start_pulse,
  output logic                status_pulse,
  output logic                readout_pulse,
  output logic                param_err
);
  localparam int REC_BYTES = TRIG_WORDS * 4;
  localparam int BODY_LEN  = OFF_TRIG1 + 2 * REC_BYTES + 2;
  localparam int IDX_W     = $clog2(BODY_LEN);

  logic                  wr_en;
  logic [IDX_W-1:0]      wr_idx;
  logic                  commit;
  logic [BODY_LEN*8-1:0] body;

  logic [7:0]            n_rate;
  logic                  n_t1, n_t2, n_and;
  logic [PWM_BITS-1:0]   n_pwm_a, n_pwm_b;
  logic [31:0]           n_depth, n_pre;
  logic [REC_W-1:0]      n_rec1, n_rec2;
  cmd_kind_e             kind;
  logic                  depth_ok;

  cfgdec_framer #(.BODY_LEN(BODY_LEN)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .commit   (commit)
  );

  cfgdec_shadow #(.BODY_LEN(BODY_LEN)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (in_data),
    .body    (body)
  );

  cfgdec_check #(
    .TRIG_WORDS (TRIG_WORDS),
    .PWM_BITS   (PWM_BITS),
    .MIN_DEPTH  (MIN_DEPTH),
    .MAX_DEPTH  (MAX_DEPTH),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_check (
    .body         (body),
    .rate_code    (n_rate),
    .trig1_en     (n_t1),
    .trig2_en     (n_t2),
    .trig_and     (n_and),
    .pwm_a        (n_pwm_a),
    .pwm_b        (n_pwm_b),
    .sample_depth (n_depth),
    .pre_depth    (n_pre),
    .trig1_rec    (n_rec1),
    .trig2_rec    (n_rec2),
    .kind         (kind),
    .depth_ok     (depth_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_code     <= '0;
      trig1_en      <= 1'b0;
      trig2_en      <= 1'b0;
      trig_and      <= 1'b0;
      pwm_a         <= '0;
      pwm_b         <= '0;
      sample_depth  <= '0;
      pre_depth     <= '0;
      trig1_rec     <= '0;
      trig2_rec     <= '0;
      start_pulse   <= 1'b0;
      status_pulse  <= 1'b0;
      readout_pulse <= 1'b0;
      param_err     <= 1'b0;
    end else begin
      start_pulse   <= 1'b0;
      status_pulse  <= 1'b0;
      readout_pulse <= 1'b0;
      if (commit) begin
        case (kind)
          CMD_START: begin
            if (depth_ok) begin
              rate_code    <= n_rate;
              trig1_en     <= n_t1;
              trig2_en     <= n_t2;
              trig_and     <= n_and;
              pwm_a        <= n_pwm_a;
              pwm_b        <= n_pwm_b;
              sample_depth <= n_depth;
              pre_depth    <= n_pre;
              trig1_rec    <= n_rec1;
              trig2_rec    <= n_rec2;
              start_pulse  <= 1'b1;
              param_err    <= 1'b0;
            end else begin
              param_err    <= 1'b1;
            end
          end
          CMD_STATUS: status_pulse  <= 1'b1;
          CMD_READ:   readout_pulse <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker #(
  parameter int TRIG_WORDS = 8,
  parameter int PWM_BITS   = 12,
  parameter int MIN_DEPTH  = 2048,
  parameter int MAX_DEPTH  = 67108864,
  parameter int ALIGN_BITS = 9,
  localparam int REC_W     = TRIG_WORDS * 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic [7:0]          rate_code,
  input logic                trig1_en,
  input logic                trig2_en,
  input logic                trig_and,
  input logic [PWM_BITS-1:0] pwm_a,
  input logic [PWM_BITS-1:0] pwm_b,
  input logic [31:0]         sample_depth,
  input logic [31:0]         pre_depth,
  input logic [REC_W-1:0]    trig1_rec,
  input logic [REC_W-1:0]    trig2_rec,
  input logic                start_pulse,
  input logic                status_pulse,
  input logic                readout_pulse,
  input logic                param_err
);
  logic [8+3+2*PWM_BITS+64+2*REC_W-1:0] cfg_all;
  logic any_pulse;

  assign cfg_all = {rate_code, trig1_en, trig2_en, trig_and, pwm_a, pwm_b,
                    sample_depth, pre_depth, trig1_rec, trig2_rec};
  assign any_pulse = start_pulse | status_pulse | readout_pulse;

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, status_pulse, readout_pulse})); // R10

  AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready); // R10

  AST_PULSE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> in_ready); // R10

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R3

  AST_CFG_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_all) |-> start_pulse); // R3

  AST_QUERY_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_pulse || readout_pulse) |-> $stable(param_err)); // R4

  AST_START_DEPTH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (sample_depth >= 32'(MIN_DEPTH)) && (sample_depth <= 32'(MAX_DEPTH)) &&
                    (sample_depth[ALIGN_BITS-1:0] == '0) && (pre_depth < sample_depth)); // R6

  AST_ERR_RISE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(param_err) |-> !start_pulse); // R6

  AST_ERR_FALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(param_err) |-> start_pulse); // R6
endmodule

bind cfg_packet_decoder cfgdec_checker #(
  .TRIG_WORDS (TRIG_WORDS),
  .PWM_BITS   (PWM_BITS),
  .MIN_DEPTH  (MIN_DEPTH),
  .MAX_DEPTH  (MAX_DEPTH),
  .ALIGN_BITS (ALIGN_BITS)
) u_cfgdec_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .rate_code     (rate_code),
  .trig1_en      (trig1_en),
  .trig2_en      (trig2_en),
  .trig_and      (trig_and),
  .pwm_a         (pwm_a),
  .pwm_b         (pwm_b),
  .sample_depth  (sample_depth),
  .pre_depth     (pre_depth),
  .trig1_rec     (trig1_rec),
  .trig2_rec     (trig2_rec),
  .start_pulse   (start_pulse),
  .status_pulse  (status_pulse),
  .readout_pulse (readout_pulse),
  .param_err     (param_err)
);

// File: tb/cfg_packet_decoder_bench.sv
`timescale 1ns/1ps
module cfg_packet_decoder_bench;
  typedef struct packed {
    logic [7:0]   rate;
    logic         e1;
    logic         e2;
    logic         andm;
    logic [11:0]  pa;
    logic [11:0]  pb;
    logic [31:0]  depth;
    logic [31:0]  pre;
    logic [255:0] t1;
    logic [255:0] t2;
  } bcfg_t;

  typedef struct packed {
    logic [1:0] kind;   // 1 start, 2 status, 3 readout
    bcfg_t      cfg;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = 8'h00;
  logic         in_ready;
  logic [7:0]   rate_code;
  logic         trig1_en, trig2_en, trig_and;
  logic [11:0]  pwm_a, pwm_b;
  logic [31:0]  sample_depth, pre_depth;
  logic [255:0] trig1_rec, trig2_rec;
  logic         start_pulse, status_pulse, readout_pulse, param_err;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  exp_t  sbq[$];
  bcfg_t m_cfg = '0;
  logic  m_err = 1'b0;

  always #5 clk = ~clk;

  cfg_packet_decoder u_cfg_packet_decoder (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .in_ready (in_ready), .rate_code (rate_code), .trig1_en (trig1_en),
    .trig2_en (trig2_en), .trig_and (trig_and), .pwm_a (pwm_a), .pwm_b (pwm_b),
    .sample_depth (sample_depth), .pre_depth (pre_depth),
    .trig1_rec (trig1_rec), .trig2_rec (trig2_rec),
    .start_pulse (start_pulse), .status_pulse (status_pulse),
    .readout_pulse (readout_pulse), .param_err (param_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [639:0] act, input logic [639:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bcfg_t actual_cfg();
    return '{rate_code, trig1_en, trig2_en, trig_and, pwm_a, pwm_b,
             sample_depth, pre_depth, trig1_rec, trig2_rec};
  endfunction

  function automatic logic [11:0] sat12(input logic [15:0] v);
    return (v > 16'd4095) ? 12'hFFF : v[11:0];
  endfunction

  function automatic bit depth_valid(input logic [31:0] d, input logic [31:0] p);
    return (d >= 32'd2048) && (d <= 32'd67108864) && (d[8:0] == 9'd0) && (p < d);
  endfunction

  function automatic logic [255:0] mkrec(input logic [31:0] seed);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = seed ^ (32'h01010101 * k);
    return r;
  endfunction

  // Monitor: pops expected items as pulses appear.
  always @(negedge clk) begin
    if (rst_n && !done && (start_pulse || status_pulse || readout_pulse)) begin
      logic [1:0] k;
      k = start_pulse ? 2'd1 : (status_pulse ? 2'd2 : 2'd3);
      chk($onehot({start_pulse, status_pulse, readout_pulse}), "R10 single pulse",
          {start_pulse, status_pulse, readout_pulse}, 3'b001);
      if (sbq.size() == 0) begin
        chk(1'b0, "R9 unexpected pulse", k, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(k == e.kind, "R3/R4/R5 pulse kind", k, e.kind);
        chk(actual_cfg() == e.cfg, "R2/R7/R8 config outputs", actual_cfg(), e.cfg);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_data  = 8'hEE;
  endtask

  task automatic send_packet(input logic [7:0] rate, input logic [7:0] flags,
                             input logic [15:0] pa, input logic [15:0] pb,
                             input logic [31:0] dep, input logic [31:0] pre,
                             input logic [255:0] t1, input logic [255:0] t2,
                             input logic [7:0] c0, input logic [7:0] c1,
                             input int gap, input string tag);
    logic [7:0] pkt [84];
    exp_t e;
    pkt[0] = 8'h7F; pkt[1] = 8'h01; pkt[2] = rate; pkt[3] = flags;
    pkt[4] = pa[7:0]; pkt[5] = pa[15:8]; pkt[6] = pb[7:0]; pkt[7] = pb[15:8];
    pkt[8] = 8'hC3; pkt[9] = 8'h3C;
    for (int i = 0; i < 4; i++) begin
      pkt[10+i] = dep[8*i +: 8];
      pkt[14+i] = pre[8*i +: 8];
    end
    for (int i = 0; i < 32; i++) begin
      pkt[18+i] = t1[8*i +: 8];
      pkt[50+i] = t2[8*i +: 8];
    end
    pkt[82] = c0; pkt[83] = c1;

    if (c0 == 8'h1A && c1 == 8'h2B) begin
      if (depth_valid(dep, pre)) begin
        m_cfg = '{rate, flags[0], flags[1], flags[2], sat12(pa), sat12(pb), dep, pre, t1, t2};
        m_err = 1'b0;
        e = '{2'd1, m_cfg};
        sbq.push_back(e);
      end else begin
        m_err = 1'b1;
      end
    end else if (c0 == 8'h3A && c1 == 8'h4B) begin
      e = '{2'd2, m_cfg};
      sbq.push_back(e);
    end else if (c0 == 8'h5A && c1 == 8'h6B) begin
      e = '{2'd3, m_cfg};
      sbq.push_back(e);
    end

    for (int i = 0; i < 84; i++) send_byte(pkt[i], gap);
    chk(in_ready == 1'b0, "R10 ready low after last byte", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, {tag, " expected pulse seen"}, sbq.size(), 0);
    chk(param_err == m_err, {"R6 param_err after ", tag}, param_err, m_err);
    chk(actual_cfg() == m_cfg, {"R3 config after ", tag}, actual_cfg(), m_cfg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(actual_cfg() == '0, "R11 reset config", actual_cfg(), 0);
    chk({start_pulse, status_pulse, readout_pulse, param_err} == 4'b0, "R11 reset flags",
        {start_pulse, status_pulse, readout_pulse, param_err}, 0);
    chk(in_ready == 1'b1, "R11 reset ready", in_ready, 1);
    rst_n = 1'b1;

    // R2 R3 R7 R8: valid start, PWM B saturates
    send_packet(8'h22, 8'h05, 16'h0ABC, 16'h1234, 32'd4096, 32'd1000,
                mkrec(32'hA5A50000), mkrec(32'h5A5A1111), 8'h1A, 8'h2B, 0, "R3 start");
    // R4: status with junk fields, with gaps
    send_packet(8'h99, 8'h02, 16'h0001, 16'h0002, 32'd7, 32'd9,
                mkrec(32'h1), mkrec(32'h2), 8'h3A, 8'h4B, 1, "R4 status");
    // R5: readout with junk fields, wider gaps
    send_packet(8'h11, 8'h07, 16'hFFFF, 16'h0000, 32'd8192, 32'd1,
                mkrec(32'h3), mkrec(32'h4), 8'h5A, 8'h6B, 2, "R5 readout");
    // R1: junk then resync through 7F 7F 01
    send_byte(8'h55, 0); send_byte(8'h7F, 0); send_byte(8'h02, 0);
    send_byte(8'h01, 0); send_byte(8'h7F, 0); send_byte(8'h7F, 0);
    send_packet(8'h1C, 8'h02, 16'h0FFF, 16'h1000, 32'd2048, 32'd2047,
                mkrec(32'hDEAD0000), mkrec(32'hBEEF0000), 8'h1A, 8'h2B, 0, "R1 resync start");
    // R6: invalid depth pairs
    send_packet(8'h01, 8'h01, 16'h0100, 16'h0200, 32'd2304, 32'd10,
                mkrec(32'h7), mkrec(32'h8), 8'h1A, 8'h2B, 0, "R6 unaligned");
    send_packet(8'h01, 8'h01, 16'h0100, 16'h0200, 32'd1536, 32'd10,
                mkrec(32'h7), mkrec(32'h8), 8'h1A, 8'h2B, 0, "R6 too small");
    send_packet(8'h01, 8'h01, 16'h0100, 16'h0200, 32'd67109376, 32'd10,
                mkrec(32'h7), mkrec(32'h8), 8'h1A, 8'h2B, 0, "R6 too large");
    send_packet(8'h01, 8'h01, 16'h0100, 16'h0200, 32'd4096, 32'd4096,
                mkrec(32'h7), mkrec(32'h8), 8'h1A, 8'h2B, 0, "R6 pre equals depth");
    // R4: status keeps param_err set
    send_packet(8'h00, 8'h00, 16'h0, 16'h0, 32'd0, 32'd0,
                mkrec(32'h9), mkrec(32'hA), 8'h3A, 8'h4B, 0, "R4 status keeps err");
    // R9: unknown command codes
    send_packet(8'h44, 8'h03, 16'h0123, 16'h0321, 32'd4096, 32'd0,
                mkrec(32'hB), mkrec(32'hC), 8'h1A, 8'h4B, 0, "R9 unknown");
    send_packet(8'h44, 8'h03, 16'h0123, 16'h0321, 32'd4096, 32'd0,
                mkrec(32'hB), mkrec(32'hC), 8'h00, 8'h00, 0, "R9 zero cmd");
    // R6: upper boundary accepted, clears param_err
    send_packet(8'h0F, 8'h06, 16'h0800, 16'h0FFE, 32'd67108864, 32'd0,
                mkrec(32'h12345678), mkrec(32'h87654321), 8'h1A, 8'h2B, 0, "R6 max depth start");

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R3 scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule